// File: doc/BRIEF.md
# Addressed Serial Attenuator Programmer

This block sits on the host side of a three-wire link to a digitally stepped RF attenuator. A caller presents a 7-bit attenuation code and a 3-bit target address, then pulses a start strobe. The code is the wanted attenuation in quarter-dB units, so 18.25 dB is code 73. The block then produces one 16-bit serial frame on a data line and a serial clock. After the frame it pulses a latch line to commit the value in the attenuator whose address straps match the target address.

All timing comes from counters running on the system clock. Parameters set the serial clock half period, the gap between the last serial clock rise and the latch rise, the latch pulse width, and a hold-off after each commit. The hold-off caps the rate at which attenuation can be changed. A strobe that arrives while a frame or its hold-off is in progress is dropped.

Top module: `atten_frame_tx`

## Requirements
- R1: After reset and whenever `busy` is low, `ser_clk`, `latch_en`, `ser_data`, `busy` and `done` are all low.
- R2: Each frame carries the 16-bit word {5'b0, addr[2:0], 1'b0, code[6:0]}. The word is sent least significant bit first, so the low byte holds the attenuation code and goes out first. Code 73 at address 3 gives 16'h0349.
- R3: `ser_data` changes only in the cycle where `ser_clk` falls or while `ser_clk` is low. It is held for at least HALF_CYC cycles before each `ser_clk` rise.
- R4: A frame has exactly 16 `ser_clk` rising edges. The clock is low for HALF_CYC cycles and high for HALF_CYC cycles. The first rise comes HALF_CYC cycles after `busy` rises.
- R5: `latch_en` is low during every serial clock pulse. It rises exactly HALF_CYC + LE_SETUP_CYC cycles after the last `ser_clk` rise and is never high together with `ser_clk`.
- R6: `latch_en` stays high for exactly LE_PULSE_CYC cycles.
- R7: `done` is a single-cycle pulse that is high only in the cycle in which `latch_en` falls.
- R8: `busy` rises in the cycle after a start is accepted. It falls exactly GAP_CYC cycles after `latch_en` falls.
- R9: A start strobe given while `busy` is high has no effect: the frame in flight, its timing and the number of frames sent are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Request one frame; sampled only when idle |
| atten_code | input | 7 | Attenuation in quarter-dB steps |
| tgt_addr | input | 3 | Address of the attenuator to update |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial shift clock |
| latch_en | output | 1 | Commit pulse after the frame |
| busy | output | 1 | Frame or hold-off in progress |
| done | output | 1 | One-cycle pulse at the commit |

## Verification
Every result has a fixed cycle offset from the event that causes it. The first clock rise comes HALF_CYC cycles after `busy` rises. Each clock edge comes HALF_CYC after the previous one. The latch rise follows the last clock rise by HALF_CYC + LE_SETUP_CYC, and the latch fall follows the latch rise by LE_PULSE_CYC. `done` appears in the same cycle as the latch fall, and `busy` falls GAP_CYC cycles after it. The bench samples on the falling system edge and timestamps every output transition with a cycle counter, so each offset is checked as an exact difference. It does not poll a window. It sweeps all 128 codes and all 8 addresses, and it injects strobes both mid-shift and during hold-off.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 3;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LE_WAIT,
    ST_LE_HIGH,
    ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/atten_frame_pack.sv
module atten_frame_pack #(
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3,
  parameter int WORD_W = 8
) (
  input  logic [CODE_W-1:0]   code,
  input  logic [ADDR_W-1:0]   addr,
  output logic [2*WORD_W-1:0] frame
);
  localparam int CPAD = WORD_W - CODE_W;
  localparam int APAD = WORD_W - ADDR_W;

  // low byte leaves first: attenuation word, then address word
  assign frame = {{APAD{1'b0}}, addr, {CPAD{1'b0}}, code};
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] q_q, q_d;
  logic         en;

  assign en  = load | shift;
  assign q_d = load ? din : {1'b0, q_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign lsb = q_q[0];

  // R9
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/atten_gap_timer.sv
module atten_gap_timer #(
  parameter int GAP_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic last
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en    = arm | (cnt_q != '0);
  assign cnt_d = arm ? GW'(GAP_CYC) : cnt_q - GW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == GW'(1));

  // R8
  gap_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (cnt_q == '0));
endmodule

// File: rtl/atten_frame_tx.sv
module atten_frame_tx
  import atten_pkg::*;
#(
  parameter int HALF_CYC     = 5,
  parameter int LE_SETUP_CYC = 1,
  parameter int LE_PULSE_CYC = 3,
  parameter int GAP_CYC      = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] atten_code,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              latch_en,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int PH_MAX0 = (HALF_CYC > LE_SETUP_CYC) ? HALF_CYC : LE_SETUP_CYC;
  localparam int PH_MAX  = (PH_MAX0 > LE_PULSE_CYC) ? PH_MAX0 : LE_PULSE_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0]  PH_SETUP = PH_W'(LE_SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  PH_PULSE = PH_W'(LE_PULSE_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  tx_state_e          state_q, state_d;
  logic [PH_W-1:0]    ph_q, ph_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               clk_q, clk_d;
  logic               le_q, le_d;
  logic               done_q, done_d;
  logic               load, shift, arm, gap_last;
  logic [FRAME_W-1:0] frame;

  atten_frame_pack #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_pack (
    .code  (atten_code),
    .addr  (tgt_addr),
    .frame (frame)
  );

  atten_shift_reg #(.W(FRAME_W)) i_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .shift (shift),
    .din   (frame),
    .lsb   (ser_data)
  );

  atten_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .last  (gap_last)
  );

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q + PH_W'(1);
    bit_d   = bit_q;
    clk_d   = clk_q;
    le_d    = le_q;
    done_d  = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    arm     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ph_d  = '0;
        bit_d = '0;
        if (start) begin
          load    = 1'b1;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (ph_q == PH_HALF) begin
          ph_d = '0;
          if (!clk_q) begin
            clk_d = 1'b1;
          end else begin
            clk_d = 1'b0;
            shift = 1'b1;
            bit_d = bit_q + BIT_W'(1);
            if (bit_q == BIT_LAST) state_d = ST_LE_WAIT;
          end
        end
      end
      ST_LE_WAIT: begin
        if (ph_q == PH_SETUP) begin
          ph_d    = '0;
          le_d    = 1'b1;
          state_d = ST_LE_HIGH;
        end
      end
      ST_LE_HIGH: begin
        if (ph_q == PH_PULSE) begin
          ph_d    = '0;
          le_d    = 1'b0;
          done_d  = 1'b1;
          arm     = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        ph_d = '0;
        if (gap_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      clk_q   <= 1'b0;
      le_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      clk_q   <= clk_d;
      le_q    <= le_d;
      done_q  <= done_d;
    end
  end

  assign ser_clk  = clk_q;
  assign latch_en = le_q;
  assign done     = done_q;
  assign busy     = (state_q != ST_IDLE);

  // R5
  clk_le_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_q && le_q));

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!clk_q && !le_q && !ser_data));

  // R3
  si_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && $past(clk_q)) |-> $stable(ser_data));

  // R7
  done_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($fell(le_q) && busy));
endmodule

// File: tb/test_atten_frame_tx.sv
module test_atten_frame_tx;
  localparam int H = 2;
  localparam int S = 1;
  localparam int P = 3;
  localparam int G = 40;

  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] code = '0;
  logic [2:0] addr = '0;
  logic       ser_data, ser_clk, latch_en, busy, done;

  atten_frame_tx #(.HALF_CYC(H), .LE_SETUP_CYC(S), .LE_PULSE_CYC(P), .GAP_CYC(G))
    i_atten_frame_tx (
      .clk(sclk), .rst_n(rst_n), .start(start), .atten_code(code), .tgt_addr(addr),
      .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en), .busy(busy), .done(done));

  always #5 sclk = ~sclk;

  int n_chk = 0, n_fail = 0, cyc = 0, frames = 0, n_sent = 0;
  bit finished = 1'b0;
  logic [15:0] exp_word = '0, word = '0;
  int nbits = 0, t_busy = 0, t_rise = 0, t_fall = 0, t_sd = 0, t_lerise = 0, t_lefall = 0;
  logic p_clk = 0, p_le = 0, p_busy = 0, p_sd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: timestamps every output transition at the falling system edge
  always @(negedge sclk) begin
    cyc++;
    if (rst_n) begin
      if (ser_data !== p_sd) t_sd = cyc;
      if (busy && !p_busy) begin t_busy = cyc; nbits = 0; word = '0; end
      if (ser_clk && !p_clk) begin
        if (nbits == 0) chk(cyc - t_busy == H, "R4 first rise", cyc - t_busy, H);
        else chk(cyc - t_fall == H, "R4 low time", cyc - t_fall, H);
        chk(cyc - t_sd >= H, "R3 data setup", cyc - t_sd, H);
        chk(!latch_en, "R5 latch low while shifting", int'(latch_en), 0);
        if (nbits < 16) word[nbits] = ser_data;
        nbits++;
        t_rise = cyc;
      end
      if (!ser_clk && p_clk) begin
        chk(cyc - t_rise == H, "R4 high time", cyc - t_rise, H);
        t_fall = cyc;
      end
      if (ser_clk && p_clk && ser_data !== p_sd)
        chk(1'b0, "R3 data moved while clock high", int'(ser_data), int'(p_sd));
      if (latch_en && !p_le) begin
        chk(nbits == 16, "R4 pulse count", nbits, 16);
        chk(cyc - t_rise == H + S, "R5 latch setup", cyc - t_rise, H + S);
        t_lerise = cyc;
      end
      if (!latch_en && p_le) begin
        chk(cyc - t_lerise == P, "R6 latch width", cyc - t_lerise, P);
        chk(done === 1'b1, "R7 done at latch fall", int'(done), 1);
        chk(word == exp_word, "R2 frame word", int'(word), int'(exp_word));
        frames++;
        t_lefall = cyc;
      end else if (done) begin
        chk(1'b0, "R7 stray done", 1, 0);
      end
      if (!busy && p_busy) begin
        chk(cyc - t_lefall == G, "R8 hold-off length", cyc - t_lefall, G);
        chk(!ser_clk && !latch_en && !ser_data && !done, "R1 idle lines",
            int'({ser_clk, latch_en, ser_data, done}), 0);
      end
    end
    p_clk = ser_clk; p_le = latch_en; p_busy = busy; p_sd = ser_data;
  end

  initial begin
    forever begin
      @(negedge sclk);
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", cyc, 150000);
        finish_up();
      end
    end
  end

  task automatic send(input logic [6:0] c, input logic [2:0] a, input bit poke);
    while (busy) @(negedge sclk);
    code = c; addr = a;
    exp_word = {5'b0, a, 1'b0, c};
    start = 1'b1;
    @(negedge sclk);
    start = 1'b0;
    n_sent++;
    chk(busy === 1'b1, "R8 busy after accept", int'(busy), 1);
    if (poke) begin
      // R9: strobe mid-shift with different content
      repeat (H * 7) @(negedge sclk);
      code = ~c; addr = ~a; start = 1'b1;
      @(negedge sclk);
      start = 1'b0;
      while (!done) @(negedge sclk);
      // R9: strobe during hold-off
      repeat (5) @(negedge sclk);
      start = 1'b1;
      @(negedge sclk);
      start = 1'b0;
    end
    while (busy) @(negedge sclk);
    if (poke) begin
      repeat (4 * H) @(negedge sclk);
      chk(!busy && !ser_clk, "R9 strobe while busy ignored", int'(busy), 0);
      chk(frames == n_sent, "R9 frame count", frames, n_sent);
    end
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    chk({ser_clk, latch_en, ser_data, busy, done} == 5'b0, "R1 reset state",
        int'({ser_clk, latch_en, ser_data, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    chk(!busy && !ser_clk && !latch_en, "R1 idle after reset", int'(busy), 0);

    for (int c = 0; c < 128; c++) begin
      logic [6:0] cv;
      cv = 7'(c);
      send(cv, cv[2:0] ^ cv[6:4], (c % 16) == 5);
    end
    for (int a = 0; a < 8; a++) send(7'd73, 3'(a), 1'b0);

    // R2: 18.25 dB at address 3
    while (busy) @(negedge sclk);
    code = 7'd73; addr = 3'd3; exp_word = 16'h0349;
    start = 1'b1;
    @(negedge sclk);
    start = 1'b0;
    n_sent++;
    while (busy) @(negedge sclk);
    chk(frames == n_sent, "R2 all frames committed", frames, n_sent);

    finish_up();
  end
endmodule